// File: doc/BRIEF.md
# Page-Boundary Store Splitter with Per-Page Write Permission

This unit sits between the store path of a processor and its memory write port. It takes one store of 0 to 16 bytes, given as a start address, a byte count and a 16-byte data vector. It checks whether the bytes run past the end of a 4096-byte page. A store that stays inside one page goes out as a single write. A store that spills over is cut at the page edge into two writes, which leave one after the other. The first write carries the bytes up to the end of the page. The second starts at the base of the following page and carries the rest.

Before each write leaves, a 16-entry table of write-enable bits is consulted, indexed by the page number bits of that write's own address. If the page is not writable, nothing of that write reaches memory. The unit halts and raises a precise fault holding the lowest address that was refused, marked as a write access. When the refused part is the second half, the first half has already completed. The fault stays up until it is acknowledged, and the unit then goes back to waiting for work. Address translation, the storage itself and fault handling lie outside the block.

Top module: `store_page_splitter`

## Requirements
- R1: After reset `req_ready` is 1, `mem_valid` and `fault` are 0, and all 16 table entries are writable.
- R2: A store with nonzero length whose low 12 address bits plus length are at most 4096 (a store that ends exactly at the page end included) leaves as one write with the request's address, length and data, when its page is writable.
- R3: A store whose low 12 address bits plus length exceed 4096 leaves as two writes. The first has the request address, length 4096 minus the low 12 bits, and the request data. The second has address plus first length, the remaining length, and the request data shifted right by 8 times the first length bits, so byte 0 of `mem_data` is the first byte not yet written.
- R4: Table entry k governs every write whose address bits [15:12] equal k. It is written through `cfg_we`, `cfg_page` and `cfg_writable`, where 1 means writable.
- R5: If the first part of a split store is writable and the second is not, the first part is written, the second is not, and a fault reports the base address of the second page.
- R6: If the page of the first (or only) part is not writable, no write occurs at all, and the fault reports the request address.
- R7: `fault` stays at 1 with a stable `fault_addr` and `fault_is_write` = 1 until `fault_ack` is 1 at a clock edge. The unit then returns to idle with `req_ready` = 1.
- R8: A store of length 0 is accepted and completes at once: no write, no fault, and `req_ready` stays 1.
- R9: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid`, `mem_addr`, `mem_len` and `mem_data` hold their values.
- R10: `req_ready` is 1 only when the unit is idle. A `req_valid` raised while `req_ready` is 0 has no effect.
- R11: Address arithmetic wraps modulo 2^32. A store crossing the top of the address space continues at address 0 and is checked against entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Store request present |
| req_ready | output | 1 | Unit idle and taking a request |
| req_addr | input | 32 | Store start address |
| req_len | input | 5 | Store byte count, 0 to 16 |
| req_data | input | 128 | Store bytes, byte 0 in bits [7:0] |
| cfg_we | input | 1 | Write one permission entry |
| cfg_page | input | 4 | Entry selected by cfg_we |
| cfg_writable | input | 1 | New write-enable value for that entry |
| mem_valid | output | 1 | Write offered to memory |
| mem_ready | input | 1 | Memory takes the offered write |
| mem_addr | output | 32 | Write start address |
| mem_len | output | 5 | Write byte count |
| mem_data | output | 128 | Write bytes, byte 0 in bits [7:0] |
| fault | output | 1 | Permission fault pending |
| fault_addr | output | 32 | Lowest refused address |
| fault_is_write | output | 1 | Access type of the fault, 1 for write |
| fault_ack | input | 1 | Clears a pending fault |

## Verification
The embedded properties assume that `req_len` never exceeds 16 and that the permission table is rewritten only while the unit is idle. A table change in the middle of an issue state could withdraw an offered write, and the hold check on the memory handshake would not cover that case. The bench drives configuration only between stores and draws lengths from 0 to 16. It stalls `mem_ready` in a repeating pattern to exercise the hold rule, and it raises `fault_ack` only after it has watched the fault sit unchanged for several cycles.

// File: rtl/sps_pkg.sv
`timescale 1ns/1ps
package sps_pkg;
    localparam int ADDR_W     = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int MAX_BYTES  = 16;
    localparam int PERM_BITS  = 4;

    localparam int LEN_W        = $clog2(MAX_BYTES + 1);
    localparam int DATA_W       = 8 * MAX_BYTES;
    localparam int PAGE_BYTES   = 1 << PAGE_SHIFT;
    localparam int PERM_ENTRIES = 1 << PERM_BITS;
    localparam int OFF_W        = PAGE_SHIFT + 1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2,
        ST_FAULT  = 2'd3
    } sps_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [DATA_W-1:0] data;
    } sub_op_t;

    function automatic logic [PERM_BITS-1:0] page_index(input logic [ADDR_W-1:0] a);
        return a[PAGE_SHIFT +: PERM_BITS];
    endfunction
endpackage

// File: rtl/sps_split_calc.sv
`timescale 1ns/1ps
module sps_split_calc
    import sps_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  logic [DATA_W-1:0] data,
    output sub_op_t           first_op,
    output sub_op_t           second_op,
    output logic              crosses
);
    localparam logic [OFF_W-1:0] PG = OFF_W'(PAGE_BYTES);

    logic [OFF_W-1:0]  offset;
    logic [OFF_W-1:0]  span_end;
    logic [OFF_W-1:0]  room;
    logic [LEN_W-1:0]  len_a;
    logic [LEN_W-1:0]  len_b;
    logic [LEN_W+2:0]  shift_bits;

    always_comb begin
        offset     = {1'b0, addr[PAGE_SHIFT-1:0]};
        span_end   = offset + OFF_W'(len);
        room       = PG - offset;
        crosses    = (span_end > PG);
        len_a      = crosses ? room[LEN_W-1:0] : len;
        len_b      = len - len_a;
        shift_bits = {len_a, 3'b000};

        first_op.addr  = addr;
        first_op.len   = len_a;
        first_op.data  = data;

        second_op.addr = addr + ADDR_W'(len_a);
        second_op.len  = len_b;
        second_op.data = data >> shift_bits;
    end
endmodule

// File: rtl/sps_perm_table.sv
`timescale 1ns/1ps
module sps_perm_table
    import sps_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [PERM_BITS-1:0] wr_idx,
    input  logic                 wr_val,
    input  logic [PERM_BITS-1:0] rd_idx,
    output logic                 rd_writable
);
    logic [PERM_ENTRIES-1:0] allow;

    for (genvar g = 0; g < PERM_ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                allow[g] <= 1'b1;
            end else if (wr_en && (wr_idx == PERM_BITS'(g))) begin
                allow[g] <= wr_val;
            end
        end
    end

    assign rd_writable = allow[rd_idx];
endmodule

// File: rtl/sps_ctrl.sv
`timescale 1ns/1ps
module sps_ctrl
    import sps_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [LEN_W-1:0]  req_len,
    input  sub_op_t           first_in,
    input  sub_op_t           second_in,
    input  logic              crosses_in,
    input  logic              page_ok,
    input  logic              mem_ready,
    input  logic              fault_ack,
    output logic              idle,
    output sub_op_t           cur_op,
    output logic              mem_valid,
    output logic              fault,
    output logic [ADDR_W-1:0] fault_addr
);
    sps_state_e        state_q, state_d;
    sub_op_t           first_q, second_q;
    logic              cross_q;
    logic [ADDR_W-1:0] fault_addr_q;
    logic              issuing;

    assign issuing   = (state_q == ST_FIRST) || (state_q == ST_SECOND);
    assign cur_op    = (state_q == ST_SECOND) ? second_q : first_q;
    assign mem_valid = issuing && page_ok;
    assign idle      = (state_q == ST_IDLE);
    assign fault     = (state_q == ST_FAULT);
    assign fault_addr = fault_addr_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid && (req_len != '0)) state_d = ST_FIRST;
            end
            ST_FIRST: begin
                if (!page_ok)       state_d = ST_FAULT;
                else if (mem_ready) state_d = cross_q ? ST_SECOND : ST_IDLE;
            end
            ST_SECOND: begin
                if (!page_ok)       state_d = ST_FAULT;
                else if (mem_ready) state_d = ST_IDLE;
            end
            ST_FAULT: begin
                if (fault_ack) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            first_q      <= '0;
            second_q     <= '0;
            cross_q      <= 1'b0;
            fault_addr_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid && (req_len != '0)) begin
                first_q  <= first_in;
                second_q <= second_in;
                cross_q  <= crosses_in;
            end
            if (issuing && !page_ok) begin
                fault_addr_q <= cur_op.addr;
            end
        end
    end

    a_r7_fault_held: assert property (@(posedge clk) disable iff (rst)
        fault && !fault_ack |=> fault && $stable(fault_addr))
        else $error("R7 fault dropped or address moved before ack");

    a_r9_offer_held: assert property (@(posedge clk) disable iff (rst)
        mem_valid && !mem_ready |=> mem_valid && $stable(cur_op))
        else $error("R9 offered write changed while stalled");

    a_r10_ready_quiet: assert property (@(posedge clk) disable iff (rst)
        idle |-> !mem_valid && !fault)
        else $error("R10 idle while writing or faulting");
endmodule

// File: rtl/store_page_splitter.sv
`timescale 1ns/1ps
module store_page_splitter
    import sps_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [LEN_W-1:0]     req_len,
    input  logic [DATA_W-1:0]    req_data,
    input  logic                 cfg_we,
    input  logic [PERM_BITS-1:0] cfg_page,
    input  logic                 cfg_writable,
    output logic                 mem_valid,
    input  logic                 mem_ready,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [LEN_W-1:0]     mem_len,
    output logic [DATA_W-1:0]    mem_data,
    output logic                 fault,
    output logic [ADDR_W-1:0]    fault_addr,
    output logic                 fault_is_write,
    input  logic                 fault_ack
);
    sub_op_t first_w, second_w, cur_w;
    logic    crosses_w;
    logic    page_ok_w;

    sps_split_calc u_split (
        .addr      (req_addr),
        .len       (req_len),
        .data      (req_data),
        .first_op  (first_w),
        .second_op (second_w),
        .crosses   (crosses_w)
    );

    sps_perm_table u_perm (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (cfg_we),
        .wr_idx      (cfg_page),
        .wr_val      (cfg_writable),
        .rd_idx      (page_index(cur_w.addr)),
        .rd_writable (page_ok_w)
    );

    sps_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_len    (req_len),
        .first_in   (first_w),
        .second_in  (second_w),
        .crosses_in (crosses_w),
        .page_ok    (page_ok_w),
        .mem_ready  (mem_ready),
        .fault_ack  (fault_ack),
        .idle       (req_ready),
        .cur_op     (cur_w),
        .mem_valid  (mem_valid),
        .fault      (fault),
        .fault_addr (fault_addr)
    );

    assign mem_addr       = cur_w.addr;
    assign mem_len        = cur_w.len;
    assign mem_data       = cur_w.data;
    assign fault_is_write = fault;

    a_r3_within_page: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (({1'b0, mem_addr[PAGE_SHIFT-1:0]} + OFF_W'(mem_len)) <= OFF_W'(PAGE_BYTES)))
        else $error("R3 write runs past a page end");

    a_r2_len_range: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_len != '0) && (mem_len <= LEN_W'(MAX_BYTES)))
        else $error("R2 write length out of range");

    a_r8_zero_len: assert property (@(posedge clk) disable iff (rst)
        req_ready && req_valid && (req_len == '0) |=> req_ready && !mem_valid && !fault)
        else $error("R8 zero-length store did work");
endmodule

// File: tb/tb_store_page_splitter.sv
`timescale 1ns/1ps
module tb_store_page_splitter;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_addr = '0;
    logic [4:0]   req_len = '0;
    logic [127:0] req_data = '0;
    logic         cfg_we = 1'b0;
    logic [3:0]   cfg_page = '0;
    logic         cfg_writable = 1'b1;
    logic         mem_valid;
    logic         mem_ready = 1'b1;
    logic [31:0]  mem_addr;
    logic [4:0]   mem_len;
    logic [127:0] mem_data;
    logic         fault;
    logic [31:0]  fault_addr;
    logic         fault_is_write;
    logic         fault_ack = 1'b0;

    always #2 clk = ~clk;

    store_page_splitter dut (.*);

    typedef struct {
        bit           is_fault;
        logic [31:0]  addr;
        logic [4:0]   len;
        logic [127:0] data;
    } exp_t;

    exp_t sb[$];
    bit   perm_mirror [16];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   stall_mode = 1'b0;
    int   cyc = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // memory ready pattern, updated just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            mem_ready = stall_mode ? ((cyc % 3) == 0) : 1'b1;
        end
    end

    // expectation model built from the requirements
    task automatic model(input logic [31:0] a, input logic [4:0] l, input logic [127:0] d);
        int   low;
        bit   crossing;
        int   l1;
        logic [31:0] a2;
        exp_t e;
        if (l == 0) return;
        low = int'(a[11:0]);
        crossing = (low + int'(l)) > 4096;
        l1 = crossing ? (4096 - low) : int'(l);
        if (!perm_mirror[a[15:12]]) begin
            e = '{1'b1, a, 5'd0, 128'd0};
            sb.push_back(e);
            return;
        end
        e = '{1'b0, a, 5'(l1), d};
        sb.push_back(e);
        if (crossing) begin
            a2 = a + 32'(l1);
            if (!perm_mirror[a2[15:12]]) begin
                e = '{1'b1, a2, 5'd0, 128'd0};
            end else begin
                e = '{1'b0, a2, 5'(int'(l) - l1), d >> (8 * l1)};
            end
            sb.push_back(e);
        end
    endtask

    // monitor: compares memory writes and faults against the queue
    logic        prev_fault = 1'b0;
    logic        prev_stall = 1'b0;
    logic [31:0] prev_addr = '0;
    logic [4:0]  prev_len = '0;
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (prev_stall) begin
                    check(mem_valid && mem_addr == prev_addr && mem_len == prev_len,
                          "R9", "stalled write held", {mem_valid, mem_addr}, {1'b1, prev_addr});
                end
                if (mem_valid && mem_ready) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R10", "unexpected write", mem_addr, 0);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        check(!e.is_fault, "R5", "write where fault expected", mem_addr, e.addr);
                        check(mem_addr == e.addr, "R3", "write address", mem_addr, e.addr);
                        check(mem_len == e.len, "R3", "write length", mem_len, e.len);
                        check(mem_data == e.data, "R2", "write data", mem_data, e.data);
                    end
                end
                if (fault && !prev_fault) begin
                    if (sb.size() == 0) begin
                        check(1'b0, "R6", "unexpected fault", fault_addr, 0);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        check(e.is_fault, "R5", "fault where write expected", fault_addr, e.addr);
                        check(fault_addr == e.addr, "R6", "fault address", fault_addr, e.addr);
                        check(fault_is_write, "R7", "access type write", fault_is_write, 1);
                    end
                end
                prev_fault = fault;
                prev_stall = mem_valid && !mem_ready;
                prev_addr  = mem_addr;
                prev_len   = mem_len;
            end
        end
    end

    // driver: one store, with optional requests poked while busy
    task automatic send(input logic [31:0] a, input logic [4:0] l,
                        input logic [127:0] d, input bit poke, input string req);
        model(a, l, d);
        @(negedge clk);
        req_addr  = a;
        req_len   = l;
        req_data  = d;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = poke;
        if (poke) begin
            req_addr = a + 32'h0000_0100;
            req_len  = 5'd3;
            req_data = ~d;
        end
        while (!req_ready) begin
            if (fault) begin
                logic [31:0] held;
                held = fault_addr;
                for (int k = 0; k < 3; k++) begin
                    @(negedge clk);
                    check(fault && fault_addr == held, "R7", "fault held until ack",
                          {fault, fault_addr}, {1'b1, held});
                end
                fault_ack = 1'b1;
                @(negedge clk);
                fault_ack = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
        check(sb.size() == 0, req, "all expected items seen", sb.size(), 0);
        check(!fault && req_ready, "R7", "idle after store", {fault, req_ready}, 2'b01);
    endtask

    task automatic set_perm(input logic [3:0] pg, input bit w);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_page = pg;
        cfg_writable = w;
        @(negedge clk);
        cfg_we = 1'b0;
        perm_mirror[pg] = w;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 0, 0);
        finish_run();
    end

    localparam logic [127:0] PAT = 128'h0f0e0d0c_0b0a0908_07060504_03020100;

    initial begin
        for (int i = 0; i < 16; i++) perm_mirror[i] = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !mem_valid && !fault, "R1", "reset outputs",
              {req_ready, mem_valid, fault}, 3'b100);

        send(32'h1000_0010, 5'd8, PAT, 1'b0, "R2");
        send(32'h0000_2FF0, 5'd16, PAT, 1'b0, "R2");
        send(32'h0000_3FFC, 5'd16, PAT, 1'b0, "R3");
        send(32'h0000_4FFF, 5'd5, ~PAT, 1'b0, "R3");

        set_perm(4'd6, 1'b0);
        send(32'h0000_5FF8, 5'd16, PAT, 1'b0, "R5");
        send(32'h0000_6100, 5'd4, PAT, 1'b0, "R6");
        send(32'h0000_6FFE, 5'd8, PAT, 1'b0, "R6");
        send(32'h0001_6000, 5'd2, PAT, 1'b0, "R4");
        send(32'h0000_6000, 5'd0, PAT, 1'b0, "R8");
        check(req_ready && !fault, "R8", "zero length leaves unit idle",
              {req_ready, fault}, 2'b10);

        set_perm(4'd6, 1'b1);
        send(32'h0000_6100, 5'd4, PAT, 1'b0, "R4");

        send(32'hFFFF_FFFA, 5'd10, PAT, 1'b0, "R11");
        set_perm(4'd0, 1'b0);
        send(32'hFFFF_FFFC, 5'd8, PAT, 1'b0, "R11");
        set_perm(4'd0, 1'b1);

        stall_mode = 1'b1;
        send(32'h0000_7FF4, 5'd16, PAT, 1'b1, "R10");
        send(32'h0000_8010, 5'd12, ~PAT, 1'b1, "R9");

        set_perm(4'd9, 1'b0);
        for (int n = 0; n < 30; n++) begin
            logic [31:0] ra;
            logic [4:0]  rl;
            logic [127:0] rd;
            ra = {16'h0, 4'($urandom_range(0, 15)), 12'($urandom_range(4080, 4095))};
            rl = 5'($urandom_range(0, 16));
            rd = {$urandom, $urandom, $urandom, $urandom};
            send(ra, rl, rd, n[0], "R3");
        end
        stall_mode = 1'b0;

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule